// File: doc/BRIEF.md
# Lane-Ripple Vector Adder/Subtractor

This execution unit treats a 16-bit register as eight independent 2-bit lanes and builds wide addition, subtraction and comparison out of repeated lane-local steps. When an instruction is accepted it reads two source registers. Each following cycle is one step. In every lane a step adds the running sum to the pending carry vector. It keeps the low two bits as the new lane sum. It moves each lane's carry bit one lane up, which is a left shift of 2 bits, to form the next carry vector. Both vectors are written to two destination registers: the result register and the shift register. Steps repeat until the shifted carry vector is zero, so carries ripple one lane per tick. The number of ticks depends on the data.

The register file lives outside the unit. The unit drives the two read addresses from the instruction fields and samples the read data combinationally in the issue cycle. It drives two registered write ports. A register that is being written in the issue cycle is forwarded to the operands, so a dependent instruction can be issued back-to-back. The busy output covers the steps. The done output pulses once, together with the final writes and the flags.

Top module: `lane2_vec_alu`

## Requirements
- R1: After reset, busy, done and both write enables are low.
- R2: Opcode 0 (ADD) writes (A+B) mod 2^16 to the result register. On done, the carry flag equals the carry out of bit 15.
- R3: Opcode 1 (SUB) adds the lane-wise inverse of B to A and injects a 1 into lane 0 on the first step only. It writes (A-B) mod 2^16 to the result register. On done, the carry flag is 1 exactly when A < B unsigned, which is a borrow.
- R4: Opcode 2 (CMP) steps exactly like SUB but never writes the result register. Its carry flag has the same meaning as for SUB.
- R5: Every step writes its shifted carry vector to the shift register. There is one write per step, and the last write is zero.
- R6: Busy stays high for exactly as many cycles as steps. A step count is the number of passes until the shifted carry vector is zero, capped at 8. For example, 0x0001+0x0002 takes 1 step, 0xFFFF+0x0001 takes 8, and 0x0001-0x0001 takes 8.
- R7: Done is high for one cycle, in the cycle after the last step. Busy is low in that cycle. The flags are valid while done is high.
- R8: An instruction presented while busy is high is dropped. Opcode 3 is reserved and is dropped as well. Neither one starts steps or writes.
- R9: An instruction issued in the cycle of a write sees the value being written for a source register at that address, not the stale register-file content.
- R10: On done, the zero flag is 1 exactly when the final 16-bit lane sum is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Instruction present this cycle |
| inst_op | input | 2 | 0 ADD, 1 SUB, 2 CMP, 3 reserved |
| inst_ra | input | 4 | First source register |
| inst_rb | input | 4 | Second source register |
| inst_rd | input | 4 | Result register |
| inst_rc | input | 4 | Shift (carry) register |
| rf_raddr_a | output | 4 | Register-file read address, first operand |
| rf_raddr_b | output | 4 | Register-file read address, second operand |
| rf_rdata_a | input | 16 | Read data, first operand |
| rf_rdata_b | input | 16 | Read data, second operand |
| rf_we_sum | output | 1 | Result write enable |
| rf_wa_sum | output | 4 | Result write address |
| rf_wd_sum | output | 16 | Result write data |
| rf_we_cy | output | 1 | Shift register write enable |
| rf_wa_cy | output | 4 | Shift register write address |
| rf_wd_cy | output | 16 | Shift register write data |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_cy | output | 1 | Carry (ADD) or borrow (SUB/CMP) |
| flag_zero | output | 1 | Final sum is zero |

## Verification
Two events can land in the same cycle: the final pair of writes of one instruction, and the operand read of the next instruction issued during its done pulse. The driver waits only for busy to fall before it issues, so every back-to-back issue lands on this overlap. One sequence makes the second instruction read the result register of the first one. The scoreboard predicts values from a sequential shadow of the register file. A stale read therefore shows up as a result mismatch. A second overlap is provoked by injecting an instruction in the middle of a long ripple. That instruction must leave no write and no extra done.

// File: rtl/lv_pkg.sv
package lv_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CMP = 2'd2,
    OP_RSV = 2'd3
  } lv_op_e;
endpackage

// File: rtl/lv_lane_step.sv
// One ripple step: per-lane add of accumulator and pending carry vector,
// lane carries moved up one lane to form the next pending vector.
module lv_lane_step #(
  parameter int NLANES = 8,
  parameter int LANE_W = 2,
  localparam int DW = NLANES * LANE_W
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] add_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] next_o,
  output logic          cout_o
);
  logic [NLANES-1:0] lane_cy;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [LANE_W:0] tot;
    logic            inj;
    if (i == 0) begin : g_inj
      assign inj = cin_i;
    end else begin : g_noinj
      assign inj = 1'b0;
    end
    assign tot = {1'b0, acc_i[i*LANE_W +: LANE_W]}
               + {1'b0, add_i[i*LANE_W +: LANE_W]}
               + {{LANE_W{1'b0}}, inj};
    assign sum_o[i*LANE_W +: LANE_W] = tot[LANE_W-1:0];
    assign lane_cy[i] = tot[LANE_W];
    if (i == 0) begin : g_n0
      assign next_o[LANE_W-1:0] = '0;
    end else begin : g_nx
      assign next_o[i*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, lane_cy[i-1]};
    end
  end

  assign cout_o = lane_cy[NLANES-1];
endmodule

// File: rtl/lv_operand_fwd.sv
// Picks the in-flight write value over register-file read data.
module lv_operand_fwd #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rf_data_i,
  input  logic          we0_i,
  input  logic [AW-1:0] wa0_i,
  input  logic [DW-1:0] wd0_i,
  input  logic          we1_i,
  input  logic [AW-1:0] wa1_i,
  input  logic [DW-1:0] wd1_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    if (we1_i && (wa1_i == addr_i))      data_o = wd1_i;
    else if (we0_i && (wa0_i == addr_i)) data_o = wd0_i;
    else                                 data_o = rf_data_i;
  end
endmodule

// File: rtl/lane2_vec_alu.sv
module lane2_vec_alu #(
  parameter int NLANES = 8,
  parameter int LANE_W = 2,
  parameter int AW     = 4,
  localparam int DW    = NLANES * LANE_W,
  localparam int CNT_W = $clog2(NLANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inst_valid,
  input  logic [1:0]    inst_op,
  input  logic [AW-1:0] inst_ra,
  input  logic [AW-1:0] inst_rb,
  input  logic [AW-1:0] inst_rd,
  input  logic [AW-1:0] inst_rc,
  output logic [AW-1:0] rf_raddr_a,
  output logic [AW-1:0] rf_raddr_b,
  input  logic [DW-1:0] rf_rdata_a,
  input  logic [DW-1:0] rf_rdata_b,
  output logic          rf_we_sum,
  output logic [AW-1:0] rf_wa_sum,
  output logic [DW-1:0] rf_wd_sum,
  output logic          rf_we_cy,
  output logic [AW-1:0] rf_wa_cy,
  output logic [DW-1:0] rf_wd_cy,
  output logic          busy,
  output logic          done,
  output logic          flag_cy,
  output logic          flag_zero
);
  import lv_pkg::*;

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NLANES - 1);

  lv_op_e           op_q;
  logic [AW-1:0]    rd_q, rc_q;
  logic [DW-1:0]    acc_q, pend_q;
  logic             cin_q, cy_acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, fcy_q, fz_q;
  logic             we_s_q, we_c_q;
  logic [AW-1:0]    wa_s_q, wa_c_q;
  logic [DW-1:0]    wd_s_q, wd_c_q;

  logic [DW-1:0]    opa, opb, step_sum, step_next;
  logic             step_cout, accept, is_sub, last_step, cy_total;

  assign rf_raddr_a = inst_ra;
  assign rf_raddr_b = inst_rb;

  lv_operand_fwd #(.AW(AW), .DW(DW)) u_fwd_a (
    .addr_i(inst_ra), .rf_data_i(rf_rdata_a),
    .we0_i(we_s_q), .wa0_i(wa_s_q), .wd0_i(wd_s_q),
    .we1_i(we_c_q), .wa1_i(wa_c_q), .wd1_i(wd_c_q),
    .data_o(opa)
  );

  lv_operand_fwd #(.AW(AW), .DW(DW)) u_fwd_b (
    .addr_i(inst_rb), .rf_data_i(rf_rdata_b),
    .we0_i(we_s_q), .wa0_i(wa_s_q), .wd0_i(wd_s_q),
    .we1_i(we_c_q), .wa1_i(wa_c_q), .wd1_i(wd_c_q),
    .data_o(opb)
  );

  lv_lane_step #(.NLANES(NLANES), .LANE_W(LANE_W)) u_step (
    .acc_i(acc_q), .add_i(pend_q), .cin_i(cin_q),
    .sum_o(step_sum), .next_o(step_next), .cout_o(step_cout)
  );

  assign accept    = inst_valid && !busy_q && (lv_op_e'(inst_op) != OP_RSV);
  assign is_sub    = (lv_op_e'(inst_op) == OP_SUB) || (lv_op_e'(inst_op) == OP_CMP);
  assign last_step = (step_next == '0) || (cnt_q == LAST_STEP);
  assign cy_total  = cy_acc_q | step_cout;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fcy_q    <= 1'b0;
      fz_q     <= 1'b0;
      we_s_q   <= 1'b0;
      we_c_q   <= 1'b0;
      wa_s_q   <= '0;
      wa_c_q   <= '0;
      wd_s_q   <= '0;
      wd_c_q   <= '0;
      op_q     <= OP_ADD;
      rd_q     <= '0;
      rc_q     <= '0;
      acc_q    <= '0;
      pend_q   <= '0;
      cin_q    <= 1'b0;
      cy_acc_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      we_s_q <= 1'b0;
      we_c_q <= 1'b0;
      if (busy_q) begin
        acc_q    <= step_sum;
        pend_q   <= step_next;
        cin_q    <= 1'b0;
        cy_acc_q <= cy_total;
        cnt_q    <= cnt_q + 1'b1;
        we_s_q   <= (op_q != OP_CMP);
        wa_s_q   <= rd_q;
        wd_s_q   <= step_sum;
        we_c_q   <= 1'b1;
        wa_c_q   <= rc_q;
        wd_c_q   <= step_next;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          fcy_q  <= (op_q == OP_ADD) ? cy_total : !cy_total;
          fz_q   <= (step_sum == '0);
        end
      end else if (accept) begin
        busy_q   <= 1'b1;
        op_q     <= lv_op_e'(inst_op);
        rd_q     <= inst_rd;
        rc_q     <= inst_rc;
        acc_q    <= opa;
        pend_q   <= is_sub ? ~opb : opb;
        cin_q    <= is_sub;
        cy_acc_q <= 1'b0;
        cnt_q    <= '0;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign flag_cy   = fcy_q;
  assign flag_zero = fz_q;
  assign rf_we_sum = we_s_q;
  assign rf_wa_sum = wa_s_q;
  assign rf_wd_sum = wd_s_q;
  assign rf_we_cy  = we_c_q;
  assign rf_wa_cy  = wa_c_q;
  assign rf_wd_cy  = wd_c_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CNT_W'(NLANES)));
  // R5
  cy_write_follows_step_chk: assert property (@(posedge clk) disable iff (rst)
    we_c_q |-> $past(busy_q));
  // R5
  final_cy_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (wd_c_q == '0));
  // R4
  cmp_no_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && op_q == OP_CMP) |=> !we_s_q);
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && inst_valid && !last_step) |=> ($stable(rd_q) && $stable(rc_q) && busy_q));
  // R8
  rsv_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && inst_valid && inst_op == 2'd3) |=> !busy_q);
endmodule

// File: tb/lane2_vec_alu_bench.sv
module lane2_vec_alu_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        inst_valid = 1'b0;
  logic [1:0]  inst_op = 2'd0;
  logic [3:0]  inst_ra = '0, inst_rb = '0, inst_rd = '0, inst_rc = '0;
  logic [3:0]  rf_raddr_a, rf_raddr_b, rf_wa_sum, rf_wa_cy;
  logic [15:0] rf_rdata_a, rf_rdata_b, rf_wd_sum, rf_wd_cy;
  logic        rf_we_sum, rf_we_cy, busy, done, flag_cy, flag_zero;

  logic [15:0] rf [16];
  logic [15:0] shadow [16];
  logic        ld_en = 1'b0;
  logic [3:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];

  always @(posedge clk) begin
    if (ld_en) rf[ld_addr] <= ld_data;
    if (rf_we_sum) rf[rf_wa_sum] <= rf_wd_sum;
    if (rf_we_cy) rf[rf_wa_cy] <= rf_wd_cy;
  end

  lane2_vec_alu u_lane2_vec_alu (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_op(inst_op),
    .inst_ra(inst_ra), .inst_rb(inst_rb), .inst_rd(inst_rd), .inst_rc(inst_rc),
    .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .rf_we_sum(rf_we_sum), .rf_wa_sum(rf_wa_sum), .rf_wd_sum(rf_wd_sum),
    .rf_we_cy(rf_we_cy), .rf_wa_cy(rf_wa_cy), .rf_wd_cy(rf_wd_cy),
    .busy(busy), .done(done), .flag_cy(flag_cy), .flag_zero(flag_zero)
  );

  typedef struct {
    logic [1:0]  op;
    logic [3:0]  rd;
    logic [3:0]  rc;
    logic [15:0] res;
    logic [15:0] rd_keep;
    logic        cy;
    logic        zero;
    int          steps;
    string       tag;
  } exp_t;

  exp_t sb [$];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Step count from the lane ripple rule (R6), result from plain arithmetic.
  function automatic int ripple_steps(input logic [1:0] op, input logic [15:0] a,
                                      input logic [15:0] b);
    logic [15:0] s, c, ns, nc;
    int cin, n;
    s = a;
    c = (op == 2'd0) ? b : ~b;
    cin = (op == 2'd0) ? 0 : 1;
    n = 0;
    do begin
      for (int l = 0; l < 8; l++) begin
        int t;
        t = int'(s[2*l +: 2]) + int'(c[2*l +: 2]) + ((l == 0) ? cin : 0);
        ns[2*l +: 2] = t[1:0];
        if (l < 7) nc[2*(l+1) +: 2] = {1'b0, t[2]};
      end
      nc[1:0] = 2'b00;
      s = ns; c = nc; cin = 0; n++;
    end while (c != 16'h0 && n < 8);
    return n;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [3:0] ra, input logic [3:0] rb,
                       input logic [3:0] rd, input logic [3:0] rc, input string tag);
    exp_t e;
    logic [15:0] a, b;
    logic [16:0] wide;
    @(negedge clk);
    while (busy) @(negedge clk);
    a = shadow[ra];
    b = shadow[rb];
    e.op = op; e.rd = rd; e.rc = rc; e.tag = tag;
    e.rd_keep = shadow[rd];
    if (op == 2'd0) begin
      wide = {1'b0, a} + {1'b0, b};
      e.res = wide[15:0];
      e.cy = wide[16];
    end else begin
      e.res = a - b;
      e.cy = (a < b);
    end
    e.zero = (e.res == 16'h0);
    e.steps = ripple_steps(op, a, b);
    if (op != 2'd2) shadow[rd] = e.res;
    shadow[rc] = 16'h0;
    sb.push_back(e);
    inst_valid = 1'b1; inst_op = op;
    inst_ra = ra; inst_rb = rb; inst_rd = rd; inst_rc = rc;
    @(posedge clk);
    #1 inst_valid = 1'b0;
  endtask

  task automatic inject(input logic [1:0] op, input logic [3:0] ra, input logic [3:0] rb,
                        input logic [3:0] rd, input logic [3:0] rc);
    @(negedge clk);
    inst_valid = 1'b1; inst_op = op;
    inst_ra = ra; inst_rb = rb; inst_rd = rd; inst_rc = rc;
    @(posedge clk);
    #1 inst_valid = 1'b0;
  endtask

  task automatic preload(input logic [3:0] addr, input logic [15:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = addr; ld_data = val;
    shadow[addr] = val;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  // Monitor: pops expected items on each done pulse.
  initial begin
    int nb, nwc;
    exp_t e;
    nb = 0; nwc = 0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (busy) nb++;
      if (rf_we_cy) nwc++;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(!busy, "R7", {e.tag, " busy at done"}, busy, 0);
          chk(nb == e.steps, "R6", {e.tag, " step count"}, nb, e.steps);
          chk(nwc == e.steps, "R5", {e.tag, " shift writes"}, nwc, e.steps);
          chk(flag_cy == e.cy, (e.op == 2'd0) ? "R2" : "R3", {e.tag, " carry flag"},
              flag_cy, e.cy);
          chk(flag_zero == e.zero, "R10", {e.tag, " zero flag"}, flag_zero, e.zero);
          nb = 0; nwc = 0;
          @(negedge clk);
          if (busy) nb++;
          chk(!done, "R7", {e.tag, " done width"}, done, 0);
          if (e.op == 2'd2)
            chk(rf[e.rd] == e.rd_keep, "R4", {e.tag, " result reg kept"}, rf[e.rd], e.rd_keep);
          else
            chk(rf[e.rd] == e.res, (e.op == 2'd0) ? "R2" : "R3", {e.tag, " result"},
                rf[e.rd], e.res);
          chk(rf[e.rc] == 16'h0, "R5", {e.tag, " shift reg final"}, rf[e.rc], 0);
        end
      end
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 16'h0;
      shadow[i] = 16'h0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!rf_we_sum && !rf_we_cy, "R1", "write enables after reset",
        {rf_we_sum, rf_we_cy}, 0);

    preload(4'd0, 16'h0001);
    preload(4'd1, 16'h0002);
    preload(4'd2, 16'hFFFF);
    preload(4'd3, 16'h0001);
    preload(4'd4, 16'h1234);
    preload(4'd5, 16'h0FED);
    preload(4'd6, 16'h8000);
    preload(4'd7, 16'h8000);
    preload(4'd13, 16'hA5A5);
    preload(4'd11, 16'h5555);
    preload(4'd12, 16'hAAAA);

    issue(2'd0, 4'd0, 4'd1, 4'd8, 4'd9, "R2 add 1+2");
    issue(2'd0, 4'd2, 4'd3, 4'd10, 4'd9, "R2 add ffff+1");
    issue(2'd1, 4'd3, 4'd3, 4'd14, 4'd9, "R3 sub 1-1");
    issue(2'd1, 4'd0, 4'd1, 4'd15, 4'd9, "R3 sub 1-2");
    issue(2'd2, 4'd4, 4'd5, 4'd13, 4'd9, "R4 cmp ne");
    issue(2'd2, 4'd6, 4'd7, 4'd13, 4'd9, "R4 cmp eq");
    issue(2'd0, 4'd6, 4'd7, 4'd14, 4'd9, "R2 add 8000+8000");
    issue(2'd0, 4'd11, 4'd12, 4'd15, 4'd9, "R2 add 5555+aaaa");
    issue(2'd0, 4'd12, 4'd12, 4'd10, 4'd9, "R2 add aaaa+aaaa");
    // R9: second reads the register written by the first, issued in its done cycle
    issue(2'd0, 4'd4, 4'd5, 4'd8, 4'd9, "R9 producer");
    issue(2'd1, 4'd8, 4'd0, 4'd15, 4'd9, "R9 consumer");
    issue(2'd1, 4'd9, 4'd8, 4'd10, 4'd14, "R9 reads shift reg");

    // R8: instruction while busy (long ripple) is dropped
    issue(2'd0, 4'd2, 4'd3, 4'd10, 4'd9, "R8 host");
    inject(2'd0, 4'd0, 4'd1, 4'd13, 4'd11);

    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rf[13] == shadow[13], "R8", "busy-time instr result reg", rf[13], shadow[13]);
    chk(rf[11] == shadow[11], "R8", "busy-time instr shift reg", rf[11], shadow[11]);

    // R8: reserved opcode at idle
    inject(2'd3, 4'd0, 4'd1, 4'd13, 4'd11);
    @(negedge clk);
    chk(!busy, "R8", "reserved op busy", busy, 0);
    chk(!rf_we_sum && !rf_we_cy, "R8", "reserved op writes", {rf_we_sum, rf_we_cy}, 0);
    repeat (3) @(negedge clk);
    chk(rf[13] == shadow[13], "R8", "reserved op result reg", rf[13], shadow[13]);
    chk(!done, "R8", "reserved op done", done, 0);

    report();
  end
endmodule